// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block produces the serial clock for an I2C master, one byte at a time. A free-running reference tick (`tick_en`) is divided by a value taken from an 8-bit control register. The register also selects the speed mode, whether a ninth acknowledge clock follows the eight data clocks, and whether the master pulls SDA low during that ninth clock.

The byte-level controller around it raises `byte_req` when it wants a byte clocked. The generator answers with an SCL waveform that starts with a low half. It gives one-cycle strobes on every SCL rising and falling edge so that a shifter can sample and launch data. It flags the acknowledge clock and releases SCL high once the byte ends. The divisor field is frozen while the interface is enabled. A divisor below the legal minimum runs as the minimum and leaves a sticky error flag set.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the register reads 00h, `scl_o` is 1 (released), `busy`, `rise_stb`, `fall_stb`, `ack_phase`, `sda_ack_low` and `div_err` are 0.
- R2: The register reads back its stored 8-bit value. Bit 7 is the acknowledge-clock enable, bit 6 is the no-acknowledge bit, bit 5 selects fast mode, and bits 4:0 are the divisor. Bits 7:5 take every write.
- R3: A write made while `iface_en` is 1 leaves bits 4:0 unchanged and still updates bits 7:5.
- R4: In standard mode (bit 5 = 0) each SCL period lasts 8 × D reference ticks, where D is the divisor in use.
- R5: In fast mode each SCL period lasts 4 × D ticks, except that a divisor of 5 gives a 10-tick period.
- R6: A divisor field below 3 runs as 3. Writing such a value with `iface_en` at 0 sets `div_err`, which stays at 1 until reset.
- R7: `byte_req` seen while idle with `iface_en` at 1 makes `busy` 1 and drives `scl_o` low on the next clock with `fall_stb`. SCL returns high and `busy` drops when the last clock's high half ends.
- R8: With bit 7 at 1 a byte has nine SCL clocks, and `ack_phase` is 1 during the ninth. With bit 7 at 0 a byte has eight clocks and `ack_phase` stays 0.
- R9: During the ninth clock `sda_ack_low` is 1 when bit 6 is 0, and 0 when bit 6 is 1.
- R10: `rise_stb` and `fall_stb` are single-cycle pulses in the cycle that `scl_o` rises or falls, and they are never 1 together.
- R11: Clearing `iface_en` mid-byte releases SCL and clears `busy` on the next clock. A `byte_req` seen while `iface_en` is 0 is ignored.
- R12: Each SCL period splits into a low half of ceil(P/2) ticks and a high half of floor(P/2) ticks. The mode, divisor and acknowledge bits are captured when a byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Reference tick, one cycle wide |
| iface_en | input | 1 | Interface enable; freezes the divisor field |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| byte_req | input | 1 | Request to clock one byte |
| busy | output | 1 | A byte is being clocked |
| scl_o | output | 1 | SCL level, 1 = released high, 0 = driven low |
| rise_stb | output | 1 | Pulse in the cycle SCL rises |
| fall_stb | output | 1 | Pulse in the cycle SCL falls |
| ack_phase | output | 1 | The ninth (acknowledge) clock is in progress |
| sda_ack_low | output | 1 | Drive SDA low to acknowledge |
| div_err | output | 1 | Sticky flag: a divisor below 3 was written |

## Verification
The hardest situation to reach is a half-period whose tick count depends on a rare corner: the fast-mode divisor of 5, a clamped divisor below 3, or a divisor write attempted while the interface is enabled. Directed writes reach each of these. Every half of every clock is then measured in reference ticks, and the tick stream is thinned by a random factor so that a miscount cannot hide behind the system clock. A random phase follows in which the configuration and the tick density are drawn from a fixed seed.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Divisor actually used: values under the floor run at the floor.
  function automatic int unsigned div_in_use(input int unsigned raw,
                                             input int unsigned floor_div);
    return (raw < floor_div) ? floor_div : raw;
  endfunction

  // Reference ticks per SCL period for a mode and a divisor in use.
  function automatic int unsigned period_ticks(input logic fast,
                                               input int unsigned d,
                                               input int unsigned turbo_div);
    if (!fast)          return 8 * d;
    if (d == turbo_div) return 2 * d;
    return 4 * d;
  endfunction

  // Low half takes the spare tick of an odd period.
  function automatic int unsigned low_half(input int unsigned p);
    return (p + 1) / 2;
  endfunction

  function automatic int unsigned high_half(input int unsigned p);
    return p / 2;
  endfunction

endpackage

// File: rtl/scl_ctrl_reg.sv
module scl_ctrl_reg #(
  parameter int DIV_W   = 5,
  parameter int MIN_DIV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iface_en,
  input  logic               reg_we,
  input  logic [DIV_W+2:0]   reg_wdata,
  output logic [DIV_W+2:0]   reg_q,
  output logic               div_err
);
  localparam int REG_W = DIV_W + 3;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       ctl_q;
  logic             err_q;

  // Named write events for the assertions.
  logic div_wr_ok;
  logic div_wr_low;
  assign div_wr_ok  = reg_we && !iface_en;
  assign div_wr_low = div_wr_ok && (32'(reg_wdata[DIV_W-1:0]) < MIN_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (reg_we)     ctl_q <= reg_wdata[REG_W-1:DIV_W];
      if (div_wr_ok)  div_q <= reg_wdata[DIV_W-1:0];
      if (div_wr_low) err_q <= 1'b1;
    end
  end

  assign reg_q   = {ctl_q, div_q};
  assign div_err = err_q;

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && iface_en) |=> (reg_q[DIV_W-1:0] == $past(reg_q[DIV_W-1:0]))); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err); // R6

endmodule

// File: rtl/scl_half_calc.sv
module scl_half_calc
  import scl_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int MIN_DIV   = 3,
  parameter int TURBO_DIV = 5,
  parameter int PER_W     = DIV_W + 3
) (
  input  logic [DIV_W-1:0] div_raw,
  input  logic             fast,
  output logic [PER_W-1:0] lo_len,
  output logic [PER_W-1:0] hi_len
);
  int unsigned d_use;
  int unsigned per;

  always_comb begin
    d_use  = div_in_use(32'(div_raw), MIN_DIV);
    per    = period_ticks(fast, d_use, TURBO_DIV);
    lo_len = PER_W'(low_half(per));
    hi_len = PER_W'(high_half(per));
  end

endmodule

// File: rtl/scl_seq.sv
module scl_seq
  import scl_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             iface_en,
  input  logic             byte_req,
  input  logic [PER_W-1:0] lo_len,
  input  logic [PER_W-1:0] hi_len,
  input  logic             ack_clk,
  input  logic             ack_bit,
  output logic             busy,
  output logic             scl_o,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             ack_phase,
  output logic             sda_ack_low
);
  localparam int BIT_W = $clog2(DATA_BITS + 2);
  localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(DATA_BITS);
  localparam logic [BIT_W-1:0] LAST_DAT = BIT_W'(DATA_BITS - 1);

  scl_phase_e       ph_q;
  logic [PER_W-1:0] cnt_q, lo_q, hi_q;
  logic [BIT_W-1:0] idx_q;
  logic             ackclk_q, ackbit_q;
  logic             scl_q, rise_q, fall_q;

  // Named internal events.
  logic             accept;
  logic             abort;
  logic [PER_W-1:0] cur_len;
  logic             half_done;
  logic             last_bit;

  assign accept    = (ph_q == PH_IDLE) && iface_en && byte_req;
  assign abort     = (ph_q != PH_IDLE) && !iface_en;
  assign cur_len   = (ph_q == PH_HIGH) ? hi_q : lo_q;
  assign half_done = (ph_q != PH_IDLE) && tick_en && (cnt_q == cur_len - 1'b1);
  assign last_bit  = ackclk_q ? (idx_q == ACK_IDX) : (idx_q == LAST_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      idx_q    <= '0;
      ackclk_q <= 1'b0;
      ackbit_q <= 1'b0;
      scl_q    <= 1'b1;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (abort) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
        scl_q <= 1'b1;
      end else begin
        unique case (ph_q)
          PH_IDLE: begin
            if (accept) begin
              ph_q     <= PH_LOW;
              lo_q     <= lo_len;
              hi_q     <= hi_len;
              ackclk_q <= ack_clk;
              ackbit_q <= ack_bit;
              idx_q    <= '0;
              cnt_q    <= '0;
              scl_q    <= 1'b0;
              fall_q   <= 1'b1;
            end
          end
          PH_LOW: begin
            if (half_done) begin
              ph_q   <= PH_HIGH;
              cnt_q  <= '0;
              scl_q  <= 1'b1;
              rise_q <= 1'b1;
            end else if (tick_en) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_HIGH: begin
            if (half_done) begin
              cnt_q <= '0;
              if (last_bit) begin
                ph_q <= PH_IDLE;
              end else begin
                ph_q   <= PH_LOW;
                idx_q  <= idx_q + 1'b1;
                scl_q  <= 1'b0;
                fall_q <= 1'b1;
              end
            end else if (tick_en) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy        = (ph_q != PH_IDLE);
  assign scl_o       = scl_q;
  assign rise_stb    = rise_q;
  assign fall_stb    = fall_q;
  assign ack_phase   = busy && (idx_q == ACK_IDX);
  assign sda_ack_low = ack_phase && !ackbit_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_o); // R7
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R10
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_o && !$past(scl_o))); // R10
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl_o && $past(scl_o))); // R10
  AST_ACK_IN_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    sda_ack_low |-> ack_phase); // R9
  AST_NINTH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_phase |-> ackclk_q); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iface_en) |=> (scl_o && !busy)); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < cur_len)); // R12

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DIV_W     = 5,
  parameter int MIN_DIV   = 3,
  parameter int TURBO_DIV = 5,
  parameter int DATA_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               iface_en,
  input  logic               reg_we,
  input  logic [DIV_W+2:0]   reg_wdata,
  output logic [DIV_W+2:0]   reg_rdata,
  input  logic               byte_req,
  output logic               busy,
  output logic               scl_o,
  output logic               rise_stb,
  output logic               fall_stb,
  output logic               ack_phase,
  output logic               sda_ack_low,
  output logic               div_err
);
  localparam int REG_W   = DIV_W + 3;
  localparam int PER_W   = DIV_W + 3;
  localparam int B_FAST  = DIV_W;
  localparam int B_NACK  = DIV_W + 1;
  localparam int B_ACKCK = DIV_W + 2;

  logic [REG_W-1:0] reg_q;
  logic [PER_W-1:0] lo_len, hi_len;

  scl_ctrl_reg #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .iface_en (iface_en),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_q    (reg_q),
    .div_err  (div_err)
  );

  scl_half_calc #(
    .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .TURBO_DIV(TURBO_DIV), .PER_W(PER_W)
  ) i_calc (
    .div_raw(reg_q[DIV_W-1:0]),
    .fast   (reg_q[B_FAST]),
    .lo_len (lo_len),
    .hi_len (hi_len)
  );

  scl_seq #(.PER_W(PER_W), .DATA_BITS(DATA_BITS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .iface_en   (iface_en),
    .byte_req   (byte_req),
    .lo_len     (lo_len),
    .hi_len     (hi_len),
    .ack_clk    (reg_q[B_ACKCK]),
    .ack_bit    (reg_q[B_NACK]),
    .busy       (busy),
    .scl_o      (scl_o),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .ack_phase  (ack_phase),
    .sda_ack_low(sda_ack_low)
  );

  assign reg_rdata = reg_q;

  AST_REQ_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !iface_en) |=> !busy); // R11

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       iface_en = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       byte_req = 1'b0;
  logic       busy, scl_o, rise_stb, fall_stb, ack_phase, sda_ack_low, div_err;

  always #5 clk = ~clk;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .iface_en(iface_en),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_req(byte_req), .busy(busy), .scl_o(scl_o), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .ack_phase(ack_phase), .sda_ack_low(sda_ack_low),
    .div_err(div_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int tick_mod = 1;
  int cycles = 0;
  logic [7:0] sh = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of the period, written from the requirements.
  function automatic int ref_period(input logic [7:0] r);
    int d;
    d = (r[4:0] < 5'd3) ? 3 : int'(r[4:0]);
    if (!r[5]) return d << 3;
    if (d == 5) return 10;
    return d << 2;
  endfunction

  // Tick source.
  initial forever begin
    @(posedge clk);
    #1 tick_en = (($urandom % tick_mod) == 0);
  end

  // Byte monitor.
  bit    mon_en = 0;
  bit    byte_done = 0;
  int    exp_lo, exp_hi, exp_bits;
  bit    exp_ackdrv;
  string per_tag = "R4";
  int    lowcnt = 0, hicnt = 0, rises = 0;
  logic  prev_busy = 1'b0, prev_scl = 1'b1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (!prev_busy && busy) begin
        chk(scl_o == 1'b0 && fall_stb, "R7 start low", int'(scl_o), 0);
        lowcnt = 0; rises = 0;
      end else if (busy && !prev_scl && scl_o) begin
        chk(lowcnt == exp_lo, {per_tag, " R12 low half"}, lowcnt, exp_lo);
        chk(rise_stb == 1'b1, "R10 rise strobe", int'(rise_stb), 1);
        chk(ack_phase == (rises == 8), "R8 ack phase", int'(ack_phase), int'(rises == 8));
        if (rises == 8)
          chk(sda_ack_low == exp_ackdrv, "R9 ack drive", int'(sda_ack_low), int'(exp_ackdrv));
        rises++;
        hicnt = 0;
      end else if (busy && prev_scl && !scl_o) begin
        chk(hicnt == exp_hi, {per_tag, " R12 high half"}, hicnt, exp_hi);
        chk(fall_stb == 1'b1, "R10 fall strobe", int'(fall_stb), 1);
        lowcnt = 0;
      end else if (prev_busy && !busy) begin
        chk(hicnt == exp_hi, {per_tag, " R12 last high half"}, hicnt, exp_hi);
        chk(scl_o == 1'b1, "R7 released at end", int'(scl_o), 1);
        byte_done = 1;
      end
      if (busy && tick_en) begin
        if (!scl_o) lowcnt++;
        else        hicnt++;
      end
    end
    prev_busy = busy;
    prev_scl  = scl_o;
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      summary_and_end();
    end
  end

  task automatic wreg(input logic [7:0] v);
    @(posedge clk); #1 reg_we = 1'b1; reg_wdata = v;
    @(posedge clk); #1 reg_we = 1'b0;
    if (!iface_en) sh = v;
    else           sh = {v[7:5], sh[4:0]};
  endtask

  task automatic run_byte();
    int p;
    p = ref_period(sh);
    exp_lo = (p + 1) >> 1;
    exp_hi = p >> 1;
    exp_bits = sh[7] ? 9 : 8;
    exp_ackdrv = !sh[6];
    per_tag = sh[5] ? "R5" : "R4";
    byte_done = 0;
    mon_en = 1;
    @(posedge clk); #1 byte_req = 1'b1;
    @(posedge clk); #1 byte_req = 1'b0;
    while (!byte_done) @(negedge clk);
    mon_en = 0;
    chk(rises == exp_bits, "R8 clock count", rises, exp_bits);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reg_rdata == 8'h00, "R1 reg", int'(reg_rdata), 0);
    chk(scl_o && !busy && !rise_stb && !fall_stb, "R1 scl idle", int'(scl_o), 1);
    chk(!ack_phase && !sda_ack_low && !div_err, "R1 flags", int'(div_err), 0);

    // R2 read-back, standard mode divisor 5 (period 40)
    wreg(8'h05);
    @(negedge clk);
    chk(reg_rdata == 8'h05, "R2 readback", int'(reg_rdata), 5);
    chk(!div_err, "R6 no error on legal", int'(div_err), 0);
    iface_en = 1'b1;
    run_byte();

    // R5 fast mode special divisor and normal divisor
    iface_en = 1'b0; wreg(8'h25); iface_en = 1'b1; run_byte();
    iface_en = 1'b0; wreg(8'h26); iface_en = 1'b1; run_byte();

    // R8/R9 ninth clock without and with acknowledge
    iface_en = 1'b0; wreg(8'hC7); iface_en = 1'b1; run_byte();
    iface_en = 1'b0; wreg(8'h87); tick_mod = 2; iface_en = 1'b1; run_byte();
    tick_mod = 1;

    // R3 divisor frozen while enabled, upper bits still written
    wreg(8'h7F);
    @(negedge clk);
    chk(reg_rdata == 8'h67, "R3 divisor frozen", int'(reg_rdata), 8'h67);
    chk(reg_rdata[7:5] == 3'b011, "R2 upper bits written", int'(reg_rdata[7:5]), 3);
    run_byte();

    // R6 clamp and sticky error
    iface_en = 1'b0; wreg(8'h01);
    @(negedge clk);
    chk(div_err == 1'b1, "R6 error set", int'(div_err), 1);
    chk(reg_rdata == 8'h01, "R2 raw readback", int'(reg_rdata), 1);
    iface_en = 1'b1; run_byte();
    iface_en = 1'b0; wreg(8'h22); iface_en = 1'b1; run_byte();
    iface_en = 1'b0; wreg(8'h09);
    @(negedge clk);
    chk(div_err == 1'b1, "R6 error sticky", int'(div_err), 1);

    // R11 abort mid-byte
    iface_en = 1'b1;
    @(posedge clk); #1 byte_req = 1'b1;
    @(posedge clk); #1 byte_req = 1'b0;
    repeat (30) @(posedge clk);
    #1 iface_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(scl_o && !busy, "R11 abort releases", int'(busy), 0);

    // R11 request ignored while disabled
    @(posedge clk); #1 byte_req = 1'b1;
    @(posedge clk); #1 byte_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && scl_o && !fall_stb, "R11 request ignored", int'(busy), 0);

    // Random configurations and tick densities
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      v[4:0] = 5'(3 + ($urandom % 29));
      tick_mod = 1 + int'($urandom % 2);
      iface_en = 1'b0;
      wreg(v);
      iface_en = 1'b1;
      run_byte();
    end
    tick_mod = 1;
    repeat (4) @(posedge clk);
    summary_and_end();
  end

endmodule